// File: doc/BRIEF.md
# Trap Value Capture Register

This block holds the trap-value register of a small processor core. When the pipeline signals a trap, the block looks at the exception cause. Depending on the cause it either loads the faulting address, loads the bits of the offending instruction, loads zero, or leaves the register alone. Between traps, software reads and writes the register through a plain register port that is addressed by a 12-bit register number.

The same module serves both privilege levels. A parameter picks the machine-level or the supervisor-level update rules, and that choice also sets the register number the block answers to. A second parameter says whether the instruction bits of an illegal instruction are captured. The register is XLEN bits wide.

The instruction input carries the first XLEN bits of the faulting instruction, lowest parcel first. The block finds the instruction's length from its low bits and clears every register bit above that length. An encoding longer than 32 bits is kept as its first XLEN bits.

The address input is stored exactly as presented. For a fetch fault in the middle of a variable-length instruction, the pipeline supplies the address of the faulting part. The start address of the instruction goes to a separate register outside this block.

Top module: `trap_value_reg`

## Requirements
- R1: While reset is asserted the register reads zero, and it is zero on the first clock after reset is released.
- R2: A software write with the block's own register number loads the write data on the next clock. A read with that number returns the register; a read or write with any other number returns zero and changes nothing.
- R3: At machine level, a trap with cause 0 (fetch misaligned), 1 (fetch access), 3 (breakpoint), 4 (load misaligned), 5 (load access), 6 (store misaligned) or 7 (store access) loads the faulting address on the next clock, unchanged.
- R4: A trap whose cause is 8 or above keeps the previous value.
- R5: With capture enabled, a machine-level trap with cause 2 (illegal instruction) loads a 16-bit instruction when bits [1:0] of the instruction are not 11. Only bits [15:0] are kept and all higher bits become zero.
- R6: With capture enabled, an illegal instruction whose bits [1:0] are 11 and whose bits [4:2] are not 111 is a 32-bit instruction. It is stored as bits [31:0], zero-extended to XLEN.
- R7: With capture enabled, an illegal instruction whose bits [4:0] are 11111 is longer than 32 bits. All XLEN supplied bits are stored.
- R8: With capture disabled, a machine-level illegal-instruction trap loads zero.
- R9: At supervisor level the register is loaded with the address for causes 0, 1, 3, 5, 6 and 7. Causes 2 and 4 leave it unchanged.
- R10: A trap that updates the register overrides a software write in the same cycle. A trap that does not update it lets that software write through.
- R11: The machine-level variant answers to register number 0x343 and the supervisor-level variant to 0x143.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| trapValid | input | 1 | One-cycle strobe: a trap is taken this cycle |
| trapCause | input | 4 | Exception cause code of the trap |
| trapAddr | input | XLEN | Faulting address for address-type causes |
| trapInst | input | XLEN | First XLEN bits of the faulting instruction |
| csrAddr | input | 12 | Register number for software read and write |
| csrWe | input | 1 | Software write enable |
| csrWdata | input | XLEN | Software write data |
| csrRdata | output | XLEN | Read data, zero unless csrAddr matches |
| trapValue | output | XLEN | Current register contents |

## Verification
A wrong cause decode shows up one clock after the trap strobe as a trapValue that moved when it should have held, or held when it should have moved. A wrong length decode shows one clock after an illegal-instruction trap as stray bits above bit 15 or bit 31, or as missing high bits of a long encoding. Since the register keeps its value until the next update, a bad load stays visible on trapValue and on the read port until a later trap or write replaces it. The bench therefore compares all three variants every cycle against a model built from the requirements.

// File: rtl/tvr_pkg.sv
package tvr_pkg;

  localparam int CAUSE_W = 4;
  localparam int CSR_ADDR_W = 12;

  localparam logic [CAUSE_W-1:0] C_FETCH_MIS = 4'd0;
  localparam logic [CAUSE_W-1:0] C_FETCH_ACC = 4'd1;
  localparam logic [CAUSE_W-1:0] C_ILLEGAL   = 4'd2;
  localparam logic [CAUSE_W-1:0] C_BREAK     = 4'd3;
  localparam logic [CAUSE_W-1:0] C_LOAD_MIS  = 4'd4;
  localparam logic [CAUSE_W-1:0] C_LOAD_ACC  = 4'd5;
  localparam logic [CAUSE_W-1:0] C_STORE_MIS = 4'd6;
  localparam logic [CAUSE_W-1:0] C_STORE_ACC = 4'd7;

  localparam logic [CSR_ADDR_W-1:0] MACH_REG_NUM = 12'h343;
  localparam logic [CSR_ADDR_W-1:0] SUPV_REG_NUM = 12'h143;

  // At most one strobe is set in any cycle; priority is settled in the control.
  typedef struct packed {
    logic takeAddr;
    logic takeInst;
    logic takeZero;
    logic takeSw;
  } tvrStrobe_t;

endpackage

// File: rtl/tvr_ctrl.sv
module tvr_ctrl
  import tvr_pkg::*;
#(
  parameter bit SUPERVISOR   = 1'b0,
  parameter bit CAPTURE_INST = 1'b1
) (
  input  logic                  trapValid,
  input  logic [CAUSE_W-1:0]    trapCause,
  input  logic [CSR_ADDR_W-1:0] csrAddr,
  input  logic                  csrWe,
  output tvrStrobe_t            strobe
);

  localparam logic [CSR_ADDR_W-1:0] OWN_NUM = SUPERVISOR ? SUPV_REG_NUM : MACH_REG_NUM;

  logic addrCause;
  logic instCause;
  logic commonAddr;
  logic trapUpdates;

  // Address-type causes shared by both levels.
  assign commonAddr = (trapCause == C_FETCH_MIS) | (trapCause == C_FETCH_ACC) |
                      (trapCause == C_BREAK)     | (trapCause == C_LOAD_ACC)  |
                      (trapCause == C_STORE_MIS) | (trapCause == C_STORE_ACC);

  generate
    if (SUPERVISOR) begin : g_supv
      // Load misaligned and illegal instruction leave the register alone.
      assign addrCause = commonAddr;
      assign instCause = 1'b0;
    end else begin : g_mach
      assign addrCause = commonAddr | (trapCause == C_LOAD_MIS);
      assign instCause = (trapCause == C_ILLEGAL);
    end
  endgenerate

  assign strobe.takeAddr = trapValid & addrCause;
  assign strobe.takeInst = trapValid & instCause & CAPTURE_INST;
  assign strobe.takeZero = trapValid & instCause & ~CAPTURE_INST;
  assign trapUpdates     = strobe.takeAddr | strobe.takeInst | strobe.takeZero;
  // A trap update wins over a concurrent software write.
  assign strobe.takeSw   = csrWe & (csrAddr == OWN_NUM) & ~trapUpdates;

endmodule

// File: rtl/tvr_datapath.sv
module tvr_datapath
  import tvr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tvrStrobe_t      strobe,
  input  logic [XLEN-1:0] trapAddr,
  input  logic [XLEN-1:0] trapInst,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] value
);

  localparam int SHORT_W = 16;
  localparam int WORD_W  = 32;

  logic            isShort;
  logic            isLong;
  logic [XLEN-1:0] instMask;
  logic [XLEN-1:0] instBits;

  // Length from the low bits: 16-bit unless [1:0]==11; longer than 32 if [4:0]==11111.
  assign isShort = (trapInst[1:0] != 2'b11);
  assign isLong  = (trapInst[4:0] == 5'b11111);

  generate
    for (genvar i = 0; i < XLEN; i++) begin : g_mask
      localparam bit IN_SHORT = (i < SHORT_W);
      localparam bit IN_WORD  = (i < WORD_W);
      assign instMask[i] = isLong | (isShort ? IN_SHORT : IN_WORD);
    end
  endgenerate

  assign instBits = trapInst & instMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (strobe.takeAddr) begin
      value <= trapAddr;
    end else if (strobe.takeInst) begin
      value <= instBits;
    end else if (strobe.takeZero) begin
      value <= '0;
    end else if (strobe.takeSw) begin
      value <= csrWdata;
    end
  end

  // R5: a short captured instruction leaves nothing above bit 15.
  assert_short_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.takeInst && trapInst[1:0] != 2'b11) |=> (value >> SHORT_W) == '0);

  // R6: a 32-bit captured instruction keeps its low word exactly.
  assert_word_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.takeInst && trapInst[1:0] == 2'b11 && trapInst[4:2] != 3'b111)
      |=> value[WORD_W-1:0] == $past(trapInst[WORD_W-1:0]));

  // R7: a long encoding is kept whole.
  assert_long_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.takeInst && trapInst[4:0] == 5'b11111) |=> value == $past(trapInst));

endmodule

// File: rtl/trap_value_reg.sv
module trap_value_reg
  import tvr_pkg::*;
#(
  parameter int XLEN         = 32,
  parameter bit SUPERVISOR   = 1'b0,
  parameter bit CAPTURE_INST = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  trapValid,
  input  logic [CAUSE_W-1:0]    trapCause,
  input  logic [XLEN-1:0]       trapAddr,
  input  logic [XLEN-1:0]       trapInst,
  input  logic [CSR_ADDR_W-1:0] csrAddr,
  input  logic                  csrWe,
  input  logic [XLEN-1:0]       csrWdata,
  output logic [XLEN-1:0]       csrRdata,
  output logic [XLEN-1:0]       trapValue
);

  localparam logic [CSR_ADDR_W-1:0] OWN_NUM = SUPERVISOR ? SUPV_REG_NUM : MACH_REG_NUM;

  tvrStrobe_t strobe;

  tvr_ctrl #(
    .SUPERVISOR  (SUPERVISOR),
    .CAPTURE_INST(CAPTURE_INST)
  ) u_ctrl (
    .trapValid(trapValid),
    .trapCause(trapCause),
    .csrAddr  (csrAddr),
    .csrWe    (csrWe),
    .strobe   (strobe)
  );

  tvr_datapath #(
    .XLEN(XLEN)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .trapAddr(trapAddr),
    .trapInst(trapInst),
    .csrWdata(csrWdata),
    .value   (trapValue)
  );

  assign csrRdata = (csrAddr == OWN_NUM) ? trapValue : '0;

  logic addrCausePort;
  assign addrCausePort = (trapCause == C_FETCH_MIS) || (trapCause == C_FETCH_ACC) ||
                         (trapCause == C_BREAK)     || (trapCause == C_LOAD_ACC)  ||
                         (trapCause == C_STORE_MIS) || (trapCause == C_STORE_ACC) ||
                         (!SUPERVISOR && trapCause == C_LOAD_MIS);

  // R1: register is clear right after reset release.
  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> trapValue == '0);

  // R2 and R11: own-number write without a trap lands next cycle.
  assert_sw_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (csrWe && csrAddr == OWN_NUM && !trapValid) |=> trapValue == $past(csrWdata));

  // R3, R9 and R10: address causes load the address even with a concurrent write.
  assert_addr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && addrCausePort) |=> trapValue == $past(trapAddr));

  // R4: causes 8 and above leave the register untouched.
  assert_high_cause_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trapValid && trapCause >= 4'd8 && !csrWe) |=> $stable(trapValue));

  // R8: no capture means illegal instruction clears the register.
  assert_nocap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!CAPTURE_INST && !SUPERVISOR && trapValid && trapCause == C_ILLEGAL) |=> trapValue == '0);

  // R9: supervisor level ignores load misaligned.
  assert_supv_loadmis_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (SUPERVISOR && trapValid && trapCause == C_LOAD_MIS && !csrWe) |=> $stable(trapValue));

  // R11: the read port is silent for any other register number.
  assert_read_decode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (csrAddr != OWN_NUM) |-> csrRdata == '0);

endmodule

// File: tb/trap_value_reg_tb.sv
module trap_value_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trapValid = 1'b0;
  logic [3:0]  trapCause = '0;
  logic [63:0] trapAddr = '0;
  logic [63:0] trapInst = '0;
  logic [11:0] csrAddr = '0;
  logic        csrWe = 1'b0;
  logic [63:0] csrWdata = '0;

  logic [63:0] val64, rd64;
  logic [31:0] valNc, rdNc, valSu, rdSu;

  always #10 clk = ~clk;  // 50 MHz

  // Machine level, capture on, 64-bit.
  trap_value_reg #(.XLEN(64), .SUPERVISOR(1'b0), .CAPTURE_INST(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .trapValid(trapValid), .trapCause(trapCause),
    .trapAddr(trapAddr), .trapInst(trapInst), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrWdata(csrWdata), .csrRdata(rd64), .trapValue(val64));

  // Machine level, capture off, 32-bit.
  trap_value_reg #(.XLEN(32), .SUPERVISOR(1'b0), .CAPTURE_INST(1'b0)) u_dutNoCap (
    .clk(clk), .rst_n(rst_n), .trapValid(trapValid), .trapCause(trapCause),
    .trapAddr(trapAddr[31:0]), .trapInst(trapInst[31:0]), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrWdata(csrWdata[31:0]), .csrRdata(rdNc), .trapValue(valNc));

  // Supervisor level, 32-bit.
  trap_value_reg #(.XLEN(32), .SUPERVISOR(1'b1), .CAPTURE_INST(1'b1)) u_dutSup (
    .clk(clk), .rst_n(rst_n), .trapValid(trapValid), .trapCause(trapCause),
    .trapAddr(trapAddr[31:0]), .trapInst(trapInst[31:0]), .csrAddr(csrAddr), .csrWe(csrWe),
    .csrWdata(csrWdata[31:0]), .csrRdata(rdSu), .trapValue(valSu));

  typedef struct {
    logic [63:0] e64;
    logic [31:0] eNc;
    logic [31:0] eSu;
    int          due;
    string       tag;
  } expItem_t;

  expItem_t    scoreQ[$];
  int          checks = 0;
  int          errors = 0;
  int          cycleCnt = 0;
  logic [63:0] m64 = '0;
  logic [31:0] mNc = '0;
  logic [31:0] mSu = '0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [63:0] fmtInst(input logic [63:0] inst);
    if (inst[1:0] != 2'b11)      return {48'b0, inst[15:0]};
    else if (inst[4:2] != 3'b111) return {32'b0, inst[31:0]};
    else                          return inst;
  endfunction

  function automatic bit machAddrCause(input logic [3:0] c);
    return (c <= 4'd7) && (c != 4'd2);
  endfunction

  function automatic bit supAddrCause(input logic [3:0] c);
    return (c <= 4'd7) && (c != 4'd2) && (c != 4'd4);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected next-state.
  task automatic drive(input logic v, input logic [3:0] c, input logic [63:0] a,
                       input logic [63:0] inst, input logic we, input logic [11:0] num,
                       input logic [63:0] wd, input string tag);
    expItem_t it;
    @(negedge clk);
    trapValid = v; trapCause = c; trapAddr = a; trapInst = inst;
    csrWe = we; csrAddr = num; csrWdata = wd;
    // machine, capture on
    if (v && machAddrCause(c))  m64 = a;
    else if (v && c == 4'd2)    m64 = fmtInst(inst);
    else if (we && num == 12'h343) m64 = wd;
    // machine, capture off
    if (v && machAddrCause(c))  mNc = a[31:0];
    else if (v && c == 4'd2)    mNc = '0;
    else if (we && num == 12'h343) mNc = wd[31:0];
    // supervisor
    if (v && supAddrCause(c))   mSu = a[31:0];
    else if (we && num == 12'h143) mSu = wd[31:0];
    it.e64 = m64; it.eNc = mNc; it.eSu = mSu; it.due = cycleCnt + 1; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 4'd0, 64'd0, 64'd0, 1'b0, 12'h000, 64'd0, tag);
  endtask

  // Read port check; the register holds during the idle cycle.
  task automatic readChk(input logic [11:0] num, input logic [63:0] e64,
                         input logic [31:0] eNc, input logic [31:0] eSu, input string tag);
    drive(1'b0, 4'd0, 64'd0, 64'd0, 1'b0, num, 64'd0, tag);
    #1;
    check({tag, " rd u_dut"}, rd64, e64);
    check({tag, " rd u_dutNoCap"}, {32'b0, rdNc}, {32'b0, eNc});
    check({tag, " rd u_dutSup"}, {32'b0, rdSu}, {32'b0, eSu});
  endtask

  // Monitor: compare values due at this cycle.
  always @(negedge clk) begin
    if (rst_n && scoreQ.size() > 0 && scoreQ[0].due == cycleCnt) begin
      expItem_t it;
      it = scoreQ.pop_front();
      check({it.tag, " u_dut"}, val64, it.e64);
      check({it.tag, " u_dutNoCap"}, {32'b0, valNc}, {32'b0, it.eNc});
      check({it.tag, " u_dutSup"}, {32'b0, valSu}, {32'b0, it.eSu});
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1: values held at zero during reset
    check("R1 in reset u_dut", val64, 64'd0);
    check("R1 in reset u_dutSup", {32'b0, valSu}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release u_dut", val64, 64'd0);
    check("R1 after release u_dutNoCap", {32'b0, valNc}, 64'd0);

    // R2 / R11: machine number write; supervisor unaffected
    drive(1'b0, 4'd0, 64'd0, 64'd0, 1'b1, 12'h343, 64'h1111_2222_3333_4444, "R2 R11 write 0x343");
    // R11: supervisor number write; machine unaffected
    drive(1'b0, 4'd0, 64'd0, 64'd0, 1'b1, 12'h143, 64'hAAAA_BBBB_CCCC_DDDD, "R11 write 0x143");
    // R2: write to a foreign number changes nothing
    drive(1'b0, 4'd0, 64'd0, 64'd0, 1'b1, 12'h340, 64'hDEAD_BEEF_DEAD_BEEF, "R2 foreign write");
    readChk(12'h343, 64'h1111_2222_3333_4444, 32'h3333_4444, 32'd0, "R2 R11 read 0x343");
    readChk(12'h143, 64'd0, 32'd0, 32'hCCCC_DDDD, "R2 R11 read 0x143");
    readChk(12'h300, 64'd0, 32'd0, 32'd0, "R2 read foreign");

    // R3 / R9: load misaligned updates machine, not supervisor
    drive(1'b1, 4'd4, 64'h8000_0000_0000_1003, 64'd0, 1'b0, 12'h000, 64'd0, "R3 R9 cause 4");
    idle("R9 hold after cause 4");
    // R3 / R9: other address causes update all levels
    for (int c = 0; c <= 7; c++) begin
      if (c != 2 && c != 4)
        drive(1'b1, 4'(c), 64'h0000_0ABC_0000_1000 + 64'(c * 'h111), 64'd0, 1'b0, 12'h000, 64'd0,
              $sformatf("R3 R9 cause %0d", c));
    end
    // R4: high causes hold
    drive(1'b1, 4'd9, 64'hFFFF_0000_FFFF_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 12'h000, 64'd0, "R4 cause 9");
    drive(1'b1, 4'd15, 64'h1234_0000_5678_0000, 64'd0, 1'b0, 12'h000, 64'd0, "R4 cause 15");

    // R5 / R8 / R9: short illegal instruction
    drive(1'b1, 4'd2, 64'hAAAA, 64'hFFFF_FFFF_FFFF_8A41, 1'b0, 12'h000, 64'd0, "R5 R8 R9 short");
    idle("R5 hold");
    // R6: 32-bit illegal instruction zero-extended
    drive(1'b1, 4'd2, 64'hAAAA, 64'hFFFF_FFFF_F073_0513, 1'b0, 12'h000, 64'd0, "R6 R8 word");
    // R7: long encoding keeps all 64 bits
    drive(1'b1, 4'd2, 64'hAAAA, 64'h9ABC_DEF0_1357_AB1F, 1'b0, 12'h000, 64'd0, "R7 R8 long");
    // R8: zero instruction is short and captures as zero
    drive(1'b1, 4'd0, 64'h5555_5555_5555_5555, 64'd0, 1'b0, 12'h000, 64'd0, "R3 preload");
    drive(1'b1, 4'd2, 64'd0, 64'd0, 1'b0, 12'h000, 64'd0, "R5 R8 zero inst");

    // R10: trap beats software write
    drive(1'b1, 4'd5, 64'h0000_0001_2345_6780, 64'd0, 1'b1, 12'h343, 64'hEEEE_EEEE_EEEE_EEEE, "R10 trap wins 0x343");
    drive(1'b1, 4'd7, 64'h0000_0002_0000_0040, 64'd0, 1'b1, 12'h143, 64'hEEEE_EEEE_EEEE_EEEE, "R10 trap wins 0x143");
    // R10 / R4: non-updating trap lets the write through
    drive(1'b1, 4'd10, 64'h0, 64'd0, 1'b1, 12'h343, 64'h0F0F_0F0F_0F0F_0F0F, "R10 R4 write passes");
    drive(1'b1, 4'd4, 64'h0000_0000_0000_0777, 64'd0, 1'b1, 12'h143, 64'h0000_0000_7777_0000, "R10 R9 sup write passes");
    // R10: illegal with capture off still overrides the write
    drive(1'b1, 4'd2, 64'd0, 64'h0000_0000_0000_0001, 1'b1, 12'h343, 64'h1234_1234_1234_1234, "R10 R8 illegal wins");
    idle("final hold");
    idle("final hold 2");
    repeat (3) @(negedge clk);
    if (scoreQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", scoreQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule